// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache that sits between a processor load/store port and a word-wide memory port. Each of its lines holds four 32-bit words. Every line has a valid bit, a dirty bit and a stored tag, and the cache as a whole holds 4 KB of data. Stores that hit change only the cache. A modified line goes back to memory only when a miss evicts it. A store miss allocates the line in the same way as a load miss.

On a miss the processor is stalled. If the victim line is dirty, its four words are written to memory first. The new block is then read from memory, starting with the word the processor asked for and wrapping around through the rest of the line. The stall drops in the cycle that first word is accepted, so the processor can restart early. The rest of the line keeps filling in the background, and any new request made in that time waits until the fill is done.

Memory transfers use a request/ready handshake. A word moves on a rising clock edge when both `mem_req` and `mem_ready` are high. The processor holds its request and its operands stable for as long as `cpu_stall` is high.

Top module: `dm_wb_cache`

## Requirements
- R1: A byte address is decoded as tag = bits [31:12], line index = bits [11:4] and word-in-line = bits [3:2]. Bits [1:0] are ignored, so any byte address within a word selects that word.
- R2: After reset no line is valid, so the first access to any index is a miss: `cpu_stall` is high and a memory transfer sequence starts.
- R3: A load that hits returns the addressed word on `cpu_rdata` in the same cycle, with `cpu_stall` low and no memory transfer.
- R4: A store that hits updates only the cached word, with `cpu_stall` low and no memory transfer. It marks the line as modified.
- R5: A miss whose victim line is unmodified, or not valid, makes no write transfers. The first transfer is a read.
- R6: A miss whose victim line is modified first writes the victim's four words to memory, at the victim's tag and index, in word order 0, 1, 2, 3 (`mem_we`=1). Only after the fourth write does the first read transfer start.
- R7: A refill reads all four words of the new block. It starts with the requested word w and continues with w+1, w+2 and w+3, taken modulo 4.
- R8: On a miss, `cpu_stall` falls in the cycle in which the first refill word is accepted. On a load miss, `cpu_rdata` in that cycle equals the word arriving on `mem_rdata`.
- R9: Any processor request made after the release and before the last refill word is accepted is stalled. It completes in the cycle after the last refill transfer.
- R10: A store miss fetches the whole block and then holds the stored word in place of the fetched word at that position. The other three words equal memory. The line is marked modified, so a later eviction writes the stored word back.
- R11: A refilled line is valid. After a load miss it is unmodified, so evicting it causes no write transfers.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` stay unchanged, and so does `mem_wdata` for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when `cpu_req` is high and `cpu_stall` is low |
| cpu_stall | output | 1 | Request not completed this cycle; hold it |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = refill read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Refill data, taken when `mem_req`, `mem_ready` and not `mem_we` |
| mem_ready | input | 1 | Memory accepts or returns the current word |

## Verification
Several properties are checked on every cycle:
- the order of the write-back words and the rule that no refill starts before the fourth write;
- the wrap-around order of the refill words within a single block;
- a stable memory request while `mem_ready` is low;
- stalling of new requests during the rest of a refill;
- no stall when a request hits with no transfer in progress;
- a dirty line is always a valid one.

The bench scenarios cover the behaviours that depend on data and history: that the words returned and written back equal a memory model of the processor's view, that a store miss holds the stored word, that a line read on a miss is evicted without a write, and that the release cycle equals the cycle of the first refill transfer.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int unsigned DMC_ADDR_W = 32;
    localparam int unsigned DMC_DATA_W = 32;
    localparam int unsigned DMC_IDX_W  = 8;
    localparam int unsigned DMC_WSEL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             inst_en,
    input  logic [TAG_W-1:0] inst_tag,
    input  logic             inst_dirty,
    input  logic             dset_en
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic             valid_q [LINES];
    logic             dirty_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
            end
        end else if (inst_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= inst_dirty;
        end else if (dset_en) begin
            dirty_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (inst_en) tag_q[wr_idx] <= inst_tag;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

    // R11: a modified line is always a valid line
    p_dirty_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dirty |-> rd_valid);
    p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(inst_en && dset_en));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned WSEL_W = 2,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned LINES = 1 << IDX_W;
    localparam int unsigned WPL   = 1 << WSEL_W;

    logic [DATA_W-1:0] bank_rd [WPL];

    for (genvar b = 0; b < WPL; b++) begin : g_bank
        localparam logic [WSEL_W-1:0] BSEL = b;
        logic [DATA_W-1:0] arr_q [LINES];
        always_ff @(posedge clk) begin
            if (wr_en && wr_wsel == BSEL) arr_q[wr_idx] <= wr_data;
        end
        assign bank_rd[b] = arr_q[rd_idx];
    end

    assign rd_data = bank_rd[rd_wsel];
endmodule

// File: rtl/dmc_miss_ctrl.sv
module dmc_miss_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned WSEL_W = 2,
    parameter int unsigned BOFF_W = 2,
    parameter int unsigned TAG_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              lookup_hit,
    input  logic              victim_valid,
    input  logic              victim_dirty,
    input  logic [TAG_W-1:0]  victim_tag,
    output logic [IDX_W-1:0]  dat_rd_idx,
    output logic [WSEL_W-1:0] dat_rd_wsel,
    input  logic [DATA_W-1:0] dat_rd_word,
    output logic              dat_wr_en,
    output logic [IDX_W-1:0]  dat_wr_idx,
    output logic [WSEL_W-1:0] dat_wr_wsel,
    output logic [DATA_W-1:0] dat_wr_data,
    output logic [IDX_W-1:0]  tag_wr_idx,
    output logic              tag_inst_en,
    output logic [TAG_W-1:0]  tag_inst_tag,
    output logic              tag_inst_dirty,
    output logic              tag_dset_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int unsigned IDX_LSB = BOFF_W + WSEL_W;
    localparam logic [WSEL_W-1:0] W_ONE  = 1;
    localparam logic [WSEL_W-1:0] W_LAST = '1;

    typedef struct packed {
        dmc_state_e        st;
        logic [WSEL_W-1:0] cnt;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  vtag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  cpu_idx_w, q_idx_w;
    logic [WSEL_W-1:0] cpu_sel_w, q_sel_w, fill_sel_w;
    logic [TAG_W-1:0]  q_tag_w;

    assign cpu_idx_w  = cpu_addr[IDX_LSB +: IDX_W];
    assign cpu_sel_w  = cpu_addr[BOFF_W +: WSEL_W];
    assign q_idx_w    = ctl_q.addr[IDX_LSB +: IDX_W];
    assign q_sel_w    = ctl_q.addr[BOFF_W +: WSEL_W];
    assign q_tag_w    = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign fill_sel_w = q_sel_w + ctl_q.cnt;

    always_comb begin
        ctl_d          = ctl_q;
        cpu_stall      = 1'b0;
        cpu_rdata      = dat_rd_word;
        dat_rd_idx     = cpu_idx_w;
        dat_rd_wsel    = cpu_sel_w;
        dat_wr_en      = 1'b0;
        dat_wr_idx     = cpu_idx_w;
        dat_wr_wsel    = cpu_sel_w;
        dat_wr_data    = cpu_wdata;
        tag_wr_idx     = cpu_idx_w;
        tag_inst_en    = 1'b0;
        tag_inst_tag   = q_tag_w;
        tag_inst_dirty = ctl_q.we;
        tag_dset_en    = 1'b0;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = dat_rd_word;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        dat_wr_en   = cpu_we;
                        tag_dset_en = cpu_we;
                    end else begin
                        cpu_stall   = 1'b1;
                        ctl_d.addr  = cpu_addr;
                        ctl_d.we    = cpu_we;
                        ctl_d.wdata = cpu_wdata;
                        ctl_d.vtag  = victim_tag;
                        ctl_d.cnt   = '0;
                        ctl_d.st    = (victim_valid && victim_dirty) ? ST_EVICT : ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                cpu_stall   = cpu_req;
                dat_rd_idx  = q_idx_w;
                dat_rd_wsel = ctl_q.cnt;
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = {ctl_q.vtag, q_idx_w, ctl_q.cnt, {BOFF_W{1'b0}}};
                mem_wdata   = dat_rd_word;
                if (mem_ready) begin
                    ctl_d.cnt = ctl_q.cnt + W_ONE;
                    if (ctl_q.cnt == W_LAST) ctl_d.st = ST_REFILL;
                end
            end
            ST_REFILL: begin
                mem_req     = 1'b1;
                mem_addr    = {q_tag_w, q_idx_w, fill_sel_w, {BOFF_W{1'b0}}};
                dat_wr_idx  = q_idx_w;
                dat_wr_wsel = fill_sel_w;
                dat_wr_en   = mem_ready;
                dat_wr_data = (ctl_q.we && ctl_q.cnt == '0) ? ctl_q.wdata : mem_rdata;
                cpu_rdata   = ctl_q.we ? ctl_q.wdata : mem_rdata;
                cpu_stall   = cpu_req && !(ctl_q.cnt == '0 && mem_ready);
                tag_wr_idx  = q_idx_w;
                if (mem_ready) begin
                    ctl_d.cnt = ctl_q.cnt + W_ONE;
                    if (ctl_q.cnt == W_LAST) begin
                        tag_inst_en = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R6: write-back words leave in ascending order
    p_evict_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && mem_addr[BOFF_W +: WSEL_W] != W_LAST)
        |=> (mem_req && mem_we && mem_addr[BOFF_W +: WSEL_W] == $past(mem_addr[BOFF_W +: WSEL_W]) + W_ONE));
    // R6: refill reads begin only after the last write-back word
    p_evict_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && mem_addr[BOFF_W +: WSEL_W] == W_LAST)
        |=> (mem_req && !mem_we));
    // R7: refill words wrap within one block
    p_fill_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && ctl_q.cnt != W_LAST)
        |=> (mem_req && !mem_we
             && mem_addr[BOFF_W +: WSEL_W] == $past(mem_addr[BOFF_W +: WSEL_W]) + W_ONE
             && $stable(mem_addr[ADDR_W-1:IDX_LSB])));
    // R12: request held while memory is not ready
    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    p_hold_wdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata));
    // R9: new requests wait for the rest of the refill
    p_fill_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_REFILL && ctl_q.cnt != '0 && cpu_req) |-> cpu_stall);
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int unsigned ADDR_W = DMC_ADDR_W,
    parameter int unsigned DATA_W = DMC_DATA_W,
    parameter int unsigned IDX_W  = DMC_IDX_W,
    parameter int unsigned WSEL_W = DMC_WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int unsigned BOFF_W  = $clog2(DATA_W / 8);
    localparam int unsigned TAG_W   = ADDR_W - IDX_W - WSEL_W - BOFF_W;
    localparam int unsigned IDX_LSB = BOFF_W + WSEL_W;

    logic              lk_valid, lk_dirty, lookup_hit;
    logic [TAG_W-1:0]  lk_tag;
    logic [IDX_W-1:0]  dat_rd_idx, dat_wr_idx, tag_wr_idx;
    logic [WSEL_W-1:0] dat_rd_wsel, dat_wr_wsel;
    logic [DATA_W-1:0] dat_rd_word, dat_wr_data;
    logic              dat_wr_en, tag_inst_en, tag_inst_dirty, tag_dset_en;
    logic [TAG_W-1:0]  tag_inst_tag;

    assign lookup_hit = lk_valid && (lk_tag == cpu_addr[ADDR_W-1 -: TAG_W]);

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (cpu_addr[IDX_LSB +: IDX_W]),
        .rd_valid   (lk_valid),
        .rd_dirty   (lk_dirty),
        .rd_tag     (lk_tag),
        .wr_idx     (tag_wr_idx),
        .inst_en    (tag_inst_en),
        .inst_tag   (tag_inst_tag),
        .inst_dirty (tag_inst_dirty),
        .dset_en    (tag_dset_en)
    );

    dmc_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (dat_rd_idx),
        .rd_wsel (dat_rd_wsel),
        .rd_data (dat_rd_word),
        .wr_en   (dat_wr_en),
        .wr_idx  (dat_wr_idx),
        .wr_wsel (dat_wr_wsel),
        .wr_data (dat_wr_data)
    );

    dmc_miss_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .WSEL_W(WSEL_W), .BOFF_W(BOFF_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_we         (cpu_we),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .cpu_rdata      (cpu_rdata),
        .cpu_stall      (cpu_stall),
        .lookup_hit     (lookup_hit),
        .victim_valid   (lk_valid),
        .victim_dirty   (lk_dirty),
        .victim_tag     (lk_tag),
        .dat_rd_idx     (dat_rd_idx),
        .dat_rd_wsel    (dat_rd_wsel),
        .dat_rd_word    (dat_rd_word),
        .dat_wr_en      (dat_wr_en),
        .dat_wr_idx     (dat_wr_idx),
        .dat_wr_wsel    (dat_wr_wsel),
        .dat_wr_data    (dat_wr_data),
        .tag_wr_idx     (tag_wr_idx),
        .tag_inst_en    (tag_inst_en),
        .tag_inst_tag   (tag_inst_tag),
        .tag_inst_dirty (tag_inst_dirty),
        .tag_dset_en    (tag_dset_en),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ready      (mem_ready),
        .mem_rdata      (mem_rdata)
    );

    // R3: a hit with no transfer in progress completes at once
    p_hit_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && lookup_hit && !mem_req) |-> !cpu_stall);
endmodule

// File: tb/dm_wb_cache_tb.sv
module dm_wb_cache_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    dm_wb_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int nchk = 0, nerr = 0;
    logic [31:0] bmem [4096];
    logic [31:0] gold [4096];
    logic        rv [256];
    logic        rdy_m [256];
    logic [19:0] rt [256];
    int          thr = 0;
    int          lg_n = 0;
    logic        lg_we [16];
    logic [31:0] lg_addr [16], lg_data [16];
    int          lg_cyc [16];
    int          hchk = 0, herr = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mk(input int t, input int i, input int w, input int b);
        logic [31:0] tv = t, iv = i, wv = w, bv = b;
        return {tv[19:0], iv[7:0], wv[1:0], bv[1:0]};
    endfunction

    // memory responder
    initial begin
        bit          pend = 0;
        logic [31:0] p_addr = '0, p_wd = '0;
        logic        p_we = 0;
        forever begin
            @(negedge clk);
            #1;
            if (pend) begin
                hchk++;
                if (!(mem_req && mem_addr == p_addr && mem_we == p_we && (!p_we || mem_wdata == p_wd)))
                    herr++;
            end
            mem_ready = (thr == 0) || ((cyc % 3) != 0);
            mem_rdata = bmem[mem_addr[13:2]];
            if (mem_req && mem_ready) begin
                if (lg_n < 16) begin
                    lg_we[lg_n] = mem_we; lg_addr[lg_n] = mem_addr;
                    lg_data[lg_n] = mem_wdata; lg_cyc[lg_n] = cyc + 1;
                end
                lg_n++;
                if (mem_we) bmem[mem_addr[13:2]] = mem_wdata;
            end
            pend = mem_req && !mem_ready;
            p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
        end
    end

    task automatic cpu_access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                              output logic [31:0] rd, output int done, output int waits);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; waits = 0;
        forever begin
            #2;
            rd = cpu_rdata;
            if (!cpu_stall) begin
                done = cyc + 1;
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic drain();
        for (int t = 0; t < 64; t++) begin
            #2;
            if (!mem_req) break;
            @(negedge clk);
        end
    endtask

    task automatic do_acc(input logic we, input logic [31:0] a, input logic [31:0] wd, input string rq);
        int idx = int'(a[11:4]);
        int w = int'(a[3:2]);
        logic [19:0] tg = a[31:12];
        bit hit = rv[idx] && rt[idx] == tg;
        bit ev = !hit && rv[idx] && rdy_m[idx];
        int nexp = hit ? 0 : (ev ? 8 : 4);
        int base = ev ? 4 : 0;
        logic [31:0] rd, ea;
        int done, waits;
        lg_n = 0;
        cpu_access(we, a, wd, rd, done, waits);
        drain();
        chk(lg_n == nexp, {rq, " transfer count"}, lg_n, nexp);
        if (hit) begin
            chk(waits == 0, {rq, " hit without stall"}, waits, 0);
        end else if (lg_n == nexp) begin
            for (int k = 0; k < 4 && ev; k++) begin
                ea = mk(int'(rt[idx]), idx, k, 0);
                chk(lg_we[k] && lg_addr[k] == ea, {rq, " R6 write-back address"}, lg_addr[k], ea);
                chk(lg_data[k] == gold[ea[13:2]], {rq, " R6 write-back data"}, lg_data[k], gold[ea[13:2]]);
            end
            for (int k = 0; k < 4; k++) begin
                ea = mk(int'(tg), idx, (w + k) % 4, 0);
                chk(!lg_we[base+k] && lg_addr[base+k] == ea, {rq, " R7 refill order"}, lg_addr[base+k], ea);
            end
            chk(done == lg_cyc[base], {rq, " R8 release cycle"}, done, lg_cyc[base]);
        end
        if (!we) chk(rd == gold[a[13:2]], {rq, " load data"}, rd, gold[a[13:2]]);
        if (we) gold[a[13:2]] = wd;
        if (!hit) begin
            rv[idx] = 1; rt[idx] = tg; rdy_m[idx] = we;
        end else if (we) begin
            rdy_m[idx] = 1;
        end
    endtask

    // watchdog
    initial begin
        wait (cyc >= 150000);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] rd1, rd2;
        int d1, d2, w1, w2;
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = (i * 32'h9E3779B1) ^ 32'h00C0FFEE;
            gold[i] = bmem[i];
        end
        for (int i = 0; i < 256; i++) begin rv[i] = 0; rdy_m[i] = 0; rt[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(!cpu_stall && !mem_req, "R2 idle after reset", {30'd0, cpu_stall, mem_req}, 0);

        // R2 R7 R8: first access misses, refill wraps from word 2
        do_acc(0, mk(0, 5, 2, 0), 0, "R2");

        // R9: request during the rest of a refill
        lg_n = 0;
        cpu_access(0, mk(0, 6, 1, 0), 0, rd1, d1, w1);
        cpu_access(0, mk(0, 6, 3, 0), 0, rd2, d2, w2);
        chk(lg_n == 4, "R9 refill length", lg_n, 4);
        chk(rd1 == gold[mk(0, 6, 1, 0) >> 2], "R8 early word", rd1, gold[mk(0, 6, 1, 0) >> 2]);
        chk(w2 > 0, "R9 stalled during refill", w2, 1);
        chk(d2 == lg_cyc[3] + 1, "R9 completes after last refill word", d2, lg_cyc[3] + 1);
        chk(rd2 == gold[mk(0, 6, 3, 0) >> 2], "R9 data after refill", rd2, gold[mk(0, 6, 3, 0) >> 2]);
        rv[6] = 1; rt[6] = '0; rdy_m[6] = 0;

        // R3 R1: hits on every word with every byte offset
        for (int k = 0; k < 4; k++)
            for (int b = 0; b < 4; b++)
                do_acc(0, mk(0, 5, k, b), 0, "R1 R3");

        // R4: store hit, then read back
        do_acc(1, mk(0, 5, 1, 2), 32'hDEAD_BEEF, "R4");
        do_acc(0, mk(0, 5, 1, 0), 0, "R4");

        // R6: dirty victim written back before refill
        do_acc(0, mk(1, 5, 0, 0), 0, "R6");
        chk(bmem[mk(0, 5, 1, 0) >> 2] == 32'hDEAD_BEEF, "R6 memory holds stored word",
            bmem[mk(0, 5, 1, 0) >> 2], 32'hDEAD_BEEF);
        // R5 R11: line filled by a load is clean, no write-back
        do_acc(0, mk(0, 5, 1, 0), 0, "R5 R11");

        // R10: store miss merges, line becomes dirty
        do_acc(1, mk(2, 9, 3, 0), 32'h1357_9BDF, "R10");
        for (int k = 0; k < 4; k++) do_acc(0, mk(2, 9, k, 0), 0, "R10");
        do_acc(0, mk(3, 9, 0, 0), 0, "R10");

        // R12: throttled memory
        thr = 1;
        do_acc(1, mk(0, 20, 0, 0), 32'h0BAD_F00D, "R12");
        do_acc(0, mk(1, 20, 2, 0), 0, "R12");
        do_acc(1, mk(2, 20, 3, 1), 32'h2468_ACE0, "R12");
        do_acc(0, mk(3, 20, 1, 0), 0, "R12");

        // sweep over every index, tags, words and access kinds
        for (int p = 0; p < 3; p++) begin
            thr = p % 2;
            for (int i = 0; i < 256; i++)
                do_acc(logic'((i ^ p) & 1), mk((i + p) % 4, i, (i + p) % 4, 0),
                       32'hA000_0000 + (p << 12) + i, "R2 R5 R6 R10 sweep");
        end
        for (int i = 0; i < 256; i++)
            do_acc(0, mk((i + 2) % 4, i, (i + 1) % 4, 3), 0, "R1 R3 sweep");

        chk(hchk > 0, "R12 throttling exercised", hchk, 1);
        chk(herr == 0, "R12 request held while not ready", herr, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule